// File: doc/BRIEF.md
# Shifter Operand and Carry Generator

This combinational unit builds the second operand of a 32-bit data-processing operation together with the carry that the shifter hands to the flags. The operand comes from one of three sources. It can be an 8-bit immediate rotated right by an even amount. It can be a register value shifted by a 5-bit amount taken from the instruction. It can be a register value shifted by an amount held in a second register.

Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. A rotate through the carry is also available, using a special immediate encoding. Amounts from a register are handled over their full 8-bit range, with separate result and carry rules for zero, 1 to 31, exactly 32 and above 32. The carry output follows the shifter only when the caller asks for flags to be set. The ALU and the register file sit outside this block.

Top module: `shifter_operand_unit`

## Requirements
- R1: When `use_imm` is 1 the operand is the rotated immediate. When it is 0 the operand is `opnd_val` shifted by `reg_amt` if `use_reg_amt` is 1, or by `imm_amt` if it is 0.
- R2: The rotated immediate is `imm_byte`, zero-extended, rotated right by 2×`imm_rot`. When `imm_rot` is nonzero the shifter carry is bit 31 of that result. When it is zero the carry is `carry_in`.
- R3: `shift_kind` is encoded as 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. For an amount n from 1 to 31, the result is the usual shift or rotate. The carry is the last bit shifted out: bit 32−n for LSL, and bit n−1 for LSR, ASR and ROR.
- R4: With the immediate amount 0, LSL passes `opnd_val` through with `carry_in` kept. LSR and ASR act as a shift by 32.
- R5: With the immediate amount 0, ROR rotates right by one through the carry. The result is `{carry_in, opnd_val[31:1]}` and the carry is `opnd_val[0]`.
- R6: Only `reg_amt[7:0]` is used. When those bits are zero, the result is `opnd_val` and the carry is `carry_in`, whatever the upper bits hold.
- R7: For an amount of exactly 32, LSL gives 0 with carry `opnd_val[0]`, and LSR gives 0 with carry `opnd_val[31]`.
- R8: For an LSL or LSR amount above 32, the result is 0 and the carry is 0.
- R9: For an ASR amount of 32 or more, every result bit equals `opnd_val[31]` and the carry equals `opnd_val[31]`.
- R10: For a register ROR amount of 32 or more, the rotation uses the amount modulo 32. When that is zero, the result is `opnd_val` and the carry is `opnd_val[31]`.
- R11: When `set_flags` is 0, `carry_out` equals `carry_in` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_amt | input | 5 | Shift amount from the instruction |
| reg_amt | input | 32 | Shift amount register, only bits 7:0 used |
| use_reg_amt | input | 1 | Take the amount from `reg_amt` |
| use_imm | input | 1 | Select the rotated immediate as the operand |
| imm_byte | input | 8 | Immediate byte |
| imm_rot | input | 4 | Immediate rotate field, rotation is twice this |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Allow the carry to be updated |
| operand_out | output | 32 | Shifter operand |
| carry_out | output | 1 | Next carry flag |

## Verification
Directed vectors sweep all four kinds at register amounts 0, 1, 31, 32, 33 and 255. These values separate the pass-through case, the ordinary shift, the exactly-32 carry rules, the above-32 rules and the modulo-32 wrap of rotation. Immediate amounts 0, 1 and 31 set the shift-by-32 and rotate-through-carry encodings apart from normal shifts. Register amounts with bits set above bit 7 show that the upper bits are ignored. Seeded random vectors across every source, with flags set or not, are compared against a bench model that shifts one bit at a time, so each carry is the bit that physically left last.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shop_imm_rot.sv
module shop_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  output logic [DATA_W-1:0] imm_val,
  output logic              imm_carry,
  output logic              imm_touch
);
  localparam int LOG_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] f_rotr(input logic [DATA_W-1:0] v,
                                                input logic [LOG_W-1:0] n);
    if (n == '0) return v;
    return (v >> n) | (v << (LOG_W'(DATA_W) - n));
  endfunction

  logic [LOG_W-1:0]  rot_amt;
  logic [DATA_W-1:0] imm_ext;

  assign rot_amt   = LOG_W'({imm_rot, 1'b0});
  assign imm_ext   = DATA_W'(imm_byte);
  assign imm_val   = f_rotr(imm_ext, rot_amt);
  assign imm_touch = (imm_rot != '0);
  assign imm_carry = imm_val[DATA_W-1];

  always_comb begin
    if (!$isunknown({imm_byte, imm_rot}) && imm_rot == '0) begin
      assert_imm_norot_R2: assert (imm_val == imm_ext && !imm_touch)
        else $error("zero rotation altered immediate");
    end
  end
endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AMT_BITS = 8
) (
  input  logic [DATA_W-1:0]   value,
  input  logic [1:0]          kind,
  input  logic [AMT_BITS-1:0] amt,
  input  logic                imm_form,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   result,
  output logic                sh_carry,
  output logic                sh_touch
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int EW    = (AMT_BITS > LOG_W + 1) ? AMT_BITS : LOG_W + 1;

  function automatic logic [DATA_W-1:0] f_rotr(input logic [DATA_W-1:0] v,
                                                input logic [LOG_W-1:0] n);
    if (n == '0) return v;
    return (v >> n) | (v << (LOG_W'(DATA_W) - n));
  endfunction

  function automatic logic [DATA_W-1:0] f_asr(input logic [DATA_W-1:0] v,
                                               input logic [LOG_W-1:0] n);
    return DATA_W'($signed(v) >>> n);
  endfunction

  shift_kind_e     kind_e;
  logic            amt_zero, rrx_sel, force_full, pass_thru;
  logic            amt_small, amt_full, amt_over;
  logic [EW-1:0]   eff_amt;
  logic [LOG_W-1:0] sh_low, lsl_pos, low_pos;

  assign kind_e     = shift_kind_e'(kind);
  assign amt_zero   = (amt == '0);
  assign rrx_sel    = imm_form && amt_zero && (kind_e == SK_ROR);
  assign force_full = imm_form && amt_zero && (kind_e == SK_LSR || kind_e == SK_ASR);
  assign pass_thru  = amt_zero && !force_full && !rrx_sel;
  assign eff_amt    = force_full ? EW'(DATA_W) : EW'(amt);
  assign amt_small  = (eff_amt != '0) && (eff_amt < EW'(DATA_W));
  assign amt_full   = (eff_amt == EW'(DATA_W));
  assign amt_over   = (eff_amt > EW'(DATA_W));
  assign sh_low     = eff_amt[LOG_W-1:0];
  assign lsl_pos    = LOG_W'(DATA_W) - sh_low;
  assign low_pos    = sh_low - 1'b1;

  always_comb begin
    result   = value;
    sh_carry = carry_in;
    sh_touch = 1'b0;
    if (rrx_sel) begin
      result   = {carry_in, value[DATA_W-1:1]};
      sh_carry = value[0];
      sh_touch = 1'b1;
    end else if (!pass_thru) begin
      sh_touch = 1'b1;
      unique case (kind_e)
        SK_LSL: begin
          if (amt_small) begin
            result   = value << sh_low;
            sh_carry = value[lsl_pos];
          end else if (amt_full) begin
            result   = '0;
            sh_carry = value[0];
          end else begin
            result   = '0;
            sh_carry = 1'b0;
          end
        end
        SK_LSR: begin
          if (amt_small) begin
            result   = value >> sh_low;
            sh_carry = value[low_pos];
          end else if (amt_full) begin
            result   = '0;
            sh_carry = value[DATA_W-1];
          end else begin
            result   = '0;
            sh_carry = 1'b0;
          end
        end
        SK_ASR: begin
          if (amt_small) begin
            result   = f_asr(value, sh_low);
            sh_carry = value[low_pos];
          end else begin
            result   = {DATA_W{value[DATA_W-1]}};
            sh_carry = value[DATA_W-1];
          end
        end
        default: begin
          if (sh_low == '0) begin
            result   = value;
            sh_carry = value[DATA_W-1];
          end else begin
            result   = f_rotr(value, sh_low);
            sh_carry = value[low_pos];
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({value, kind, amt, imm_form, carry_in})) begin
      if (amt_over && (kind_e == SK_LSL || kind_e == SK_LSR)) begin
        assert_over_zero_R8: assert (result == '0 && sh_carry == 1'b0)
          else $error("oversized logical shift not cleared");
      end
      if (kind_e == SK_ASR && (amt_full || amt_over)) begin
        assert_asr_fill_R9: assert (result == {DATA_W{value[DATA_W-1]}} && sh_carry == value[DATA_W-1])
          else $error("wide arithmetic shift not sign filled");
      end
      if (rrx_sel) begin
        assert_rrx_shape_R5: assert (result[DATA_W-1] == carry_in && result[DATA_W-2:0] == value[DATA_W-1:1])
          else $error("rotate through carry malformed");
      end
      if (pass_thru) begin
        assert_zero_amt_R6: assert (result == value && !sh_touch)
          else $error("zero amount changed operand");
      end
    end
  end
endmodule

// File: rtl/shop_carry_mux.sv
module shop_carry_mux (
  input  logic use_imm,
  input  logic imm_carry,
  input  logic imm_touch,
  input  logic sh_carry,
  input  logic sh_touch,
  input  logic set_flags,
  input  logic carry_in,
  output logic carry_out
);
  logic src_carry, src_touch;

  assign src_carry = use_imm ? imm_carry : sh_carry;
  assign src_touch = use_imm ? imm_touch : sh_touch;
  assign carry_out = (set_flags && src_touch) ? src_carry : carry_in;

  always_comb begin
    if (!$isunknown({set_flags, carry_in, carry_out}) && !set_flags) begin
      assert_hold_carry_R11: assert (carry_out == carry_in)
        else $error("carry moved without set-flags");
    end
  end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import shop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AMT_BITS = 8,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int IAMT_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_val,
  input  logic [1:0]        shift_kind,
  input  logic [IAMT_W-1:0] imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic              use_reg_amt,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              carry_in,
  input  logic              set_flags,
  output logic [DATA_W-1:0] operand_out,
  output logic              carry_out
);
  logic [AMT_BITS-1:0] amt_sel;
  logic [DATA_W-1:0]   imm_val, sh_val;
  logic                imm_carry, imm_touch, sh_carry, sh_touch;
  logic                reg_upper_nz;

  assign amt_sel      = use_reg_amt ? reg_amt[AMT_BITS-1:0] : AMT_BITS'(imm_amt);
  assign reg_upper_nz = |reg_amt[DATA_W-1:AMT_BITS];

  shop_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_byte (imm_byte),
    .imm_rot  (imm_rot),
    .imm_val  (imm_val),
    .imm_carry(imm_carry),
    .imm_touch(imm_touch)
  );

  shop_barrel #(.DATA_W(DATA_W), .AMT_BITS(AMT_BITS)) u_bar (
    .value   (opnd_val),
    .kind    (shift_kind),
    .amt     (amt_sel),
    .imm_form(!use_reg_amt),
    .carry_in(carry_in),
    .result  (sh_val),
    .sh_carry(sh_carry),
    .sh_touch(sh_touch)
  );

  shop_carry_mux u_cmux (
    .use_imm  (use_imm),
    .imm_carry(imm_carry),
    .imm_touch(imm_touch),
    .sh_carry (sh_carry),
    .sh_touch (sh_touch),
    .set_flags(set_flags),
    .carry_in (carry_in),
    .carry_out(carry_out)
  );

  assign operand_out = use_imm ? imm_val : sh_val;

  always_comb begin
    if (!$isunknown({use_imm, use_reg_amt, reg_amt, opnd_val, carry_in})) begin
      if (!use_imm && use_reg_amt && reg_amt[AMT_BITS-1:0] == '0 && reg_upper_nz) begin
        assert_upper_ignored_R6: assert (operand_out == opnd_val && carry_out == carry_in)
          else $error("upper amount bits had an effect");
      end
      if (use_imm) begin
        assert_imm_source_R1: assert (operand_out == imm_val)
          else $error("immediate source not selected");
      end
    end
  end
endmodule

// File: tb/sim_shifter_operand_unit.sv
module sim_shifter_operand_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] opnd_val, reg_amt, operand_out;
  logic [1:0]  shift_kind;
  logic [4:0]  imm_amt;
  logic        use_reg_amt, use_imm, carry_in, set_flags, carry_out;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;

  int checks = 0, errors = 0;
  bit done = 0;

  shifter_operand_unit u0 (
    .opnd_val(opnd_val), .shift_kind(shift_kind), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .use_reg_amt(use_reg_amt), .use_imm(use_imm),
    .imm_byte(imm_byte), .imm_rot(imm_rot), .carry_in(carry_in),
    .set_flags(set_flags), .operand_out(operand_out), .carry_out(carry_out)
  );

  // Bench model: moves one bit per step, the carry is whatever fell off last.
  function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
      input logic [4:0] ia, input logic [31:0] ra, input logic ur, input logic ui,
      input logic [7:0] ib, input logic [3:0] ir, input logic ci, input logic sf);
    logic [31:0] r;
    logic c;
    int n;
    c = ci;
    if (ui) begin
      r = {24'd0, ib};
      for (int i = 0; i < 2 * int'(ir); i++) r = {r[0], r[31:1]};
      if (ir != 0) c = r[31];
    end else begin
      r = v;
      n = ur ? int'(ra[7:0]) : int'(ia);
      if (!ur && ia == 0 && k == 2'd3) begin
        c = v[0];
        r = {ci, v[31:1]};
        n = 0;
      end else if (!ur && ia == 0 && (k == 2'd1 || k == 2'd2)) begin
        n = 32;
      end
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0:    begin c = r[31]; r = {r[30:0], 1'b0}; end
          2'd1:    begin c = r[0];  r = {1'b0, r[31:1]}; end
          2'd2:    begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0];  r = {r[0], r[31:1]}; end
        endcase
      end
    end
    if (!sf) c = ci;
    return {c, r};
  endfunction

  function automatic string tag(input logic [1:0] k, input logic [4:0] ia,
      input logic [31:0] ra, input logic ur, input logic ui, input logic sf);
    string t;
    int n;
    if (ui) t = "R1 R2";
    else if (!ur) t = (ia == 0) ? ((k == 2'd3) ? "R5" : "R4") : "R1 R3";
    else begin
      n = int'(ra[7:0]);
      if (n == 0) t = "R6";
      else if (n < 32) t = (ra[31:8] != 0) ? "R6 R3" : "R3";
      else if (k == 2'd2) t = "R9";
      else if (k == 2'd3) t = "R10";
      else if (n == 32) t = "R7";
      else t = "R8";
    end
    if (!sf) t = {t, " R11"};
    return t;
  endfunction

  task automatic run(input logic [31:0] v, input logic [1:0] k, input logic [4:0] ia,
      input logic [31:0] ra, input logic ur, input logic ui, input logic [7:0] ib,
      input logic [3:0] ir, input logic ci, input logic sf);
    logic [32:0] exp;
    @(negedge clk);
    opnd_val = v; shift_kind = k; imm_amt = ia; reg_amt = ra; use_reg_amt = ur;
    use_imm = ui; imm_byte = ib; imm_rot = ir; carry_in = ci; set_flags = sf;
    @(posedge clk);
    #1;
    exp = model(v, k, ia, ra, ur, ui, ib, ir, ci, sf);
    checks++;
    if (operand_out !== exp[31:0] || carry_out !== exp[32]) begin
      errors++;
      $display("FAIL %s: kind=%0d amt=%0d/%0h src=%0d/%0d v=%h got %h c%0b exp %h c%0b",
               tag(k, ia, ra, ur, ui, sf), k, ia, ra, ur, ui, v,
               operand_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int amts[6];
    logic [31:0] pats[3];
    amts = '{0, 1, 31, 32, 33, 255};
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_3C5A};
    opnd_val = '0; shift_kind = '0; imm_amt = '0; reg_amt = '0; use_reg_amt = 0;
    use_imm = 0; imm_byte = '0; imm_rot = '0; carry_in = 0; set_flags = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // reset-time idle state, R1
    if (operand_out !== 32'd0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got %h c%0b exp 00000000 c0", operand_out, carry_out);
    end
    rst = 0;
    void'($urandom(32'd1234));

    // R3 R6 R7 R8 R9 R10: register amounts over every kind
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 6; a++)
        for (int p = 0; p < 3; p++)
          for (int c = 0; c < 2; c++)
            run(pats[p], 2'(k), 5'd0, 32'(amts[a]), 1'b1, 1'b0, 8'h0, 4'h0, 1'(c), 1'b1);
    // R4 R5 R3: immediate amounts 0, 1, 31
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 3; p++)
        for (int c = 0; c < 2; c++) begin
          run(pats[p], 2'(k), 5'd0,  '0, 1'b0, 1'b0, 8'h0, 4'h0, 1'(c), 1'b1);
          run(pats[p], 2'(k), 5'd1,  '0, 1'b0, 1'b0, 8'h0, 4'h0, 1'(c), 1'b1);
          run(pats[p], 2'(k), 5'd31, '0, 1'b0, 1'b0, 8'h0, 4'h0, 1'(c), 1'b1);
        end
    // R6: upper amount bits ignored
    for (int k = 0; k < 4; k++) begin
      run(32'hDEAD_BEEF, 2'(k), 5'd0, 32'hFFFF_FF00, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, 1'b1);
      run(32'hDEAD_BEEF, 2'(k), 5'd0, 32'h0000_0121, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, 1'b1);
    end
    // R2: rotated immediates, zero and nonzero rotation
    for (int r = 0; r < 16; r++) begin
      run(32'h0, 2'd0, 5'd0, '0, 1'b0, 1'b1, 8'hC1, 4'(r), 1'b0, 1'b1);
      run(32'h0, 2'd0, 5'd0, '0, 1'b0, 1'b1, 8'h7E, 4'(r), 1'b1, 1'b1);
    end
    // R11: flags held with set-flags low
    for (int k = 0; k < 4; k++) begin
      run(32'h8000_0001, 2'(k), 5'd0, 32'd33, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, 1'b0);
      run(32'h8000_0001, 2'(k), 5'd0, '0,     1'b0, 1'b0, 8'h0, 4'h0, 1'b0, 1'b0);
    end
    run(32'h0, 2'd0, 5'd0, '0, 1'b0, 1'b1, 8'h80, 4'h4, 1'b0, 1'b0);
    // Random mix over every source (R1)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra;
      ra = $urandom;
      if (i % 3 == 0) ra = ra & 32'h3F;
      run($urandom, 2'($urandom), 5'($urandom), ra, 1'($urandom), 1'($urandom % 4 == 0),
          8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom % 5 != 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule